// File: doc/BRIEF.md
# Two-Wire Bus Slave with High-Speed Mode Entry

This block is the slave end of a two-wire serial bus (I2C-compatible). A fast system clock samples the raw clock and data lines. Each line passes through a synchronizer and a counter-based glitch filter. START, repeated START and STOP conditions are then decoded from the filtered lines. The first byte after any START is compared with the slave's 7-bit address. That address is a fixed 4-bit upper part (a parameter) joined to three strap inputs, so eight slaves can share one bus. The slave acknowledges a matching address and any byte it receives, and it shifts out bytes on reads.

The block also recognises the high-speed master code, a first byte of the form 0000_1xxx. It answers that code with a not-acknowledge and raises a high-speed flag. The flag holds through repeated STARTs and clears only at the next STOP. The data line is driven through an open-drain enable: a 1 pulls the line low, and a 0 releases it. Register logic sees a one-cycle strobe with each received byte. It also sees a one-cycle request each time the slave needs a byte to transmit.

Top module: `i2c_hs_slave`

## Requirements
- R1: After reset, the slave releases the data line (`sda_oe`=0), and `hs_mode`, `rx_valid` and `tx_req` are 0.
- R2: The slave address is {ADDR_HI, addr_strap}, with ADDR_HI in bits 6:3 and the strap in bits 2:0. The first byte after a START holds the address in bits 7:1 and R/W in bit 0, where 1 means read. On a match the slave pulls the data line low through the ninth clock. On a mismatch it leaves the line released, and it acknowledges nothing more until the next START.
- R3: In a write (R/W=0), the slave receives each following byte MSB first. It presents the byte on `rx_data` with a one-cycle `rx_valid`, and it acknowledges the byte on its ninth clock.
- R4: In a read (R/W=1), the slave pulses `tx_req` once for each byte it sends and captures `tx_data` on the clock edge that ends the `tx_req` cycle. It sends the byte MSB first, changing the data line only after SCL falls. A master acknowledge asks for another byte; a master not-acknowledge ends the read.
- R5: A first byte with bits 7:3 equal to 00001 is the high-speed master code. The slave leaves the data line released on its ninth clock and sets `hs_mode` by the end of that clock.
- R6: `hs_mode` stays 1 through repeated STARTs, and transfers addressed in high-speed mode are acknowledged and received normally.
- R7: A STOP clears `hs_mode` and ends any transfer in progress. A byte clocked after a STOP without a new START is not acknowledged.
- R8: A repeated START at any point returns the slave to the address phase, so a write can be followed by a read in one transaction.
- R9: A pulse on SDA or SCL lasting fewer than FILT_LEN system clocks has no effect. A short low pulse on SDA while SCL is high is not taken as a START.
- R10: `rx_valid` and `tx_req` are single-cycle strobes and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (resolved bus value) |
| addr_strap | input | 3 | Lower three bits of the slave address |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| hs_mode | output | 1 | High-speed mode flag |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| tx_req | output | 1 | One-cycle request for the next byte to send |
| tx_data | input | 8 | Byte to send, captured at the end of the tx_req cycle |

## Verification
A wrong bit counter or phase flag shows up within one byte. It appears as an acknowledge on the wrong clock, a received byte shifted by one place, or a read byte arriving one bit late, so the checks compare every ninth-clock bus level and every byte against values the bench computes. A stale high-speed flag shows at `hs_mode` as soon as a STOP has been filtered. A filter that lets glitches through turns a short data pulse into a false START, and the slave then acknowledges an address byte it should have ignored. Random addresses, straps, directions and lengths are mixed with directed master-code, abort and repeated-START sequences.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [4:0] HS_CODE_HI = 5'b00001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ
    } i2cs_state_e;

    typedef enum logic [1:0] {
        DEC_WRITE,
        DEC_READ,
        DEC_MCODE
    } i2cs_dec_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
        return b[7:3] == HS_CODE_HI;
    endfunction

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   flt_q;
    logic                   sync_w;

    assign sync_w = sync_q[SYNC_STAGES-1];
    assign line_o = flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= 1'b1;
            cnt_q <= '0;
        end else if (sync_w == flt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            flt_q <= sync_w;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_q != $past(flt_q)) |-> ($past(sync_w) == flt_q && $past(cnt_q) == CW'(FILT_LEN - 1)));

endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.scl_rise = scl_f & ~scl_p;
        ev.scl_fall = ~scl_f & scl_p;
        ev.start    = scl_f & scl_p & sda_p & ~sda_f;
        ev.stop     = scl_f & scl_p & ~sda_p & sda_f;
        ev.sda      = sda_f;
    end

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
    import i2cs_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        addr_strap,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sda_oe,
    output logic              hs_mode,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_req
);
    i2cs_state_e       st_q;
    i2cs_dec_e         dec_q;
    logic [CNT_W-1:0]  bitn_q;
    logic              ack_q;
    logic              mack_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic              oe_q, hs_q, rxv_q, txr_q;
    logic [BYTE_W-1:0] rxd_q;
    logic              bit_slot;

    assign bit_slot = (bitn_q < ACK_SLOT);
    assign sda_oe   = oe_q;
    assign hs_mode  = hs_q;
    assign rx_valid = rxv_q;
    assign rx_data  = rxd_q;
    assign tx_req   = txr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            dec_q   <= DEC_WRITE;
            bitn_q  <= '0;
            ack_q   <= 1'b0;
            mack_q  <= 1'b0;
            sh_q    <= '0;
            tx_sh_q <= '0;
            oe_q    <= 1'b0;
            hs_q    <= 1'b0;
            rxv_q   <= 1'b0;
            rxd_q   <= '0;
            txr_q   <= 1'b0;
        end else begin
            rxv_q <= 1'b0;
            txr_q <= 1'b0;
            if (txr_q) tx_sh_q <= tx_data;
            if (ev.stop) begin
                st_q   <= ST_IDLE;
                hs_q   <= 1'b0;
                oe_q   <= 1'b0;
                ack_q  <= 1'b0;
                bitn_q <= '0;
            end else if (ev.start) begin
                st_q   <= ST_ADDR;
                oe_q   <= 1'b0;
                ack_q  <= 1'b0;
                bitn_q <= '0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_WRITE: begin
                        if (ev.scl_rise && bit_slot) begin
                            sh_q   <= {sh_q[BYTE_W-2:0], ev.sda};
                            bitn_q <= bitn_q + 1'b1;
                        end
                        if (ev.scl_fall && bitn_q == ACK_SLOT && !ack_q) begin
                            ack_q <= 1'b1;
                            if (st_q == ST_WRITE) begin
                                rxv_q <= 1'b1;
                                rxd_q <= sh_q;
                                oe_q  <= 1'b1;
                            end else if (is_hs_code(sh_q)) begin
                                dec_q <= DEC_MCODE;
                                hs_q  <= 1'b1;
                            end else if (sh_q[7:1] == {ADDR_HI, addr_strap}) begin
                                dec_q <= sh_q[0] ? DEC_READ : DEC_WRITE;
                                txr_q <= sh_q[0];
                                oe_q  <= 1'b1;
                            end else begin
                                st_q  <= ST_IDLE;
                                ack_q <= 1'b0;
                            end
                        end else if (ev.scl_fall && ack_q) begin
                            ack_q  <= 1'b0;
                            oe_q   <= 1'b0;
                            bitn_q <= '0;
                            if (st_q == ST_ADDR) begin
                                unique case (dec_q)
                                    DEC_MCODE: st_q <= ST_IDLE;
                                    DEC_READ: begin
                                        st_q <= ST_READ;
                                        oe_q <= ~tx_sh_q[BYTE_W-1];
                                    end
                                    default:   st_q <= ST_WRITE;
                                endcase
                            end
                        end
                    end
                    ST_READ: begin
                        if (ev.scl_rise && bit_slot) begin
                            bitn_q <= bitn_q + 1'b1;
                        end else if (ev.scl_rise && ack_q) begin
                            mack_q <= ~ev.sda;
                            txr_q  <= ~ev.sda;
                        end
                        if (ev.scl_fall && bit_slot && bitn_q != '0) begin
                            tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                            oe_q    <= ~tx_sh_q[BYTE_W-2];
                        end else if (ev.scl_fall && bitn_q == ACK_SLOT && !ack_q) begin
                            oe_q  <= 1'b0;
                            ack_q <= 1'b1;
                        end else if (ev.scl_fall && ack_q) begin
                            ack_q  <= 1'b0;
                            bitn_q <= '0;
                            if (mack_q) oe_q <= ~tx_sh_q[BYTE_W-1];
                            else        st_q <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !oe_q);

    // R5
    hs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_q) |-> ($past(st_q) == ST_ADDR && $past(ev.scl_fall) && !oe_q));

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!hs_q && !oe_q && st_q == ST_IDLE));

    // R10
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rxv_q |=> !rxv_q);

    // R10
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        txr_q |=> !txr_q);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rxv_q && txr_q));

    // R3
    rx_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        rxv_q |-> (st_q == ST_WRITE && oe_q));

endmodule

// File: rtl/i2c_hs_slave.sv
module i2c_hs_slave
    import i2cs_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b1010,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_strap,
    output logic       sda_oe,
    output logic       hs_mode,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       tx_req,
    input  logic [7:0] tx_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_w;
    logic [N_LINES-1:0] flt_w;
    bus_ev_t            ev_w;

    assign raw_w = {sda_i, scl_i};

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        i2cs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk   (clk),
            .rst   (rst),
            .line_i(raw_w[i]),
            .line_o(flt_w[i])
        );
    end

    i2cs_cond_detect u_det (
        .clk  (clk),
        .rst  (rst),
        .scl_f(flt_w[0]),
        .sda_f(flt_w[1]),
        .ev   (ev_w)
    );

    i2cs_byte_engine #(
        .ADDR_HI(ADDR_HI)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev_w),
        .addr_strap(addr_strap),
        .tx_data   (tx_data),
        .sda_oe    (sda_oe),
        .hs_mode   (hs_mode),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_req    (tx_req)
    );

endmodule

// File: tb/tb_i2c_hs_slave.sv
`timescale 1ns/1ps
module tb_i2c_hs_slave;
    localparam int Q = 20;
    localparam logic [3:0] HI = 4'b1010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [7:0] tx_data = 8'h00;
    logic sda_oe, hs_mode, rx_valid, tx_req;
    logic [7:0] rx_data;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_hs_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_strap(strap), .sda_oe(sda_oe), .hs_mode(hs_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req),
        .tx_data(tx_data)
    );

    int checks = 0, fails = 0;
    int rx_cnt = 0, tx_i = 0, strobe_bad = 0;
    logic [7:0] rx_log [64];
    logic [7:0] txv [64];
    logic rxv_p = 1'b0, txr_p = 1'b0;
    bit done = 1'b0;

    // R10 monitor and byte-interface model
    always @(negedge clk) begin
        if (!rst) begin
            if ((rx_valid && rxv_p) || (tx_req && txr_p) || (rx_valid && tx_req)) strobe_bad++;
            if (rx_valid) begin rx_log[rx_cnt % 64] = rx_data; rx_cnt++; end
            if (tx_req) begin tx_data = txv[tx_i % 64]; tx_i++; end
        end
        rxv_p = rx_valid;
        txr_p = tx_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        acked = (sda_bus == 1'b0);
        w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
            b[i] = sda_bus;
            w(Q); scl_m = 1'b0; w(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(1);
        sda_m = 1'b1; w(Q - 1);
    endtask

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input bit rd);
        return {HI, s, rd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int base, rxb;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) txv[i] = 8'($urandom);
        w(10);
        rst = 1'b0;
        w(3);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(hs_mode == 1'b0, "R1 hs_mode", hs_mode, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);

        // R2 R3 matching write
        strap = 3'b101;
        rxb = rx_cnt;
        bus_start();
        wr_byte(addr_byte(3'b101, 0), ack); chk(ack, "R2 addr ack", ack, 1);
        wr_byte(8'h3C, ack); chk(ack, "R3 data ack", ack, 1);
        wr_byte(8'hC3, ack); chk(ack, "R3 data ack", ack, 1);
        bus_stop();
        chk(rx_cnt == rxb + 2, "R3 rx count", rx_cnt - rxb, 2);
        chk(rx_log[rxb % 64] == 8'h3C, "R3 rx byte0", rx_log[rxb % 64], 8'h3C);
        chk(rx_log[(rxb + 1) % 64] == 8'hC3, "R3 rx byte1", rx_log[(rxb + 1) % 64], 8'hC3);

        // R2 mismatching address
        rxb = rx_cnt;
        bus_start();
        wr_byte(addr_byte(3'b100, 0), ack); chk(!ack, "R2 mismatch nack", ack, 0);
        wr_byte(8'h55, ack); chk(!ack, "R2 mismatch data nack", ack, 0);
        bus_stop();
        chk(rx_cnt == rxb, "R2 mismatch no rx", rx_cnt - rxb, 0);

        // R4 read three bytes
        base = tx_i;
        bus_start();
        wr_byte(addr_byte(3'b101, 1), ack); chk(ack, "R4 read addr ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            rd_byte(k != 2, b);
            chk(b == txv[(base + k) % 64], "R4 read byte", b, txv[(base + k) % 64]);
        end
        bus_stop();
        chk(tx_i == base + 3, "R4 tx_req count", tx_i - base, 3);

        // R5 R6 R8 high-speed entry then write, repeated start, read
        bus_start();
        wr_byte(8'h0B, ack); chk(!ack, "R5 master code nack", ack, 0);
        chk(hs_mode == 1'b1, "R5 hs_mode set", hs_mode, 1);
        rxb = rx_cnt;
        bus_start();
        wr_byte(addr_byte(3'b101, 0), ack); chk(ack, "R6 hs addr ack", ack, 1);
        wr_byte(8'h99, ack); chk(ack, "R6 hs data ack", ack, 1);
        chk(rx_cnt == rxb + 1 && rx_log[rxb % 64] == 8'h99, "R6 hs rx", rx_log[rxb % 64], 8'h99);
        chk(hs_mode == 1'b1, "R6 hs_mode held", hs_mode, 1);
        base = tx_i;
        bus_start();
        wr_byte(addr_byte(3'b101, 1), ack); chk(ack, "R8 rstart read ack", ack, 1);
        rd_byte(0, b);
        chk(b == txv[base % 64], "R8 rstart read byte", b, txv[base % 64]);
        chk(hs_mode == 1'b1, "R6 hs_mode after rstart", hs_mode, 1);
        bus_stop();
        chk(hs_mode == 1'b0, "R7 stop clears hs", hs_mode, 0);

        // R7 abort: STOP then byte without START
        bus_start();
        wr_byte(addr_byte(3'b101, 0), ack); chk(ack, "R7 pre-abort ack", ack, 1);
        bus_stop();
        rxb = rx_cnt;
        wr_byte(addr_byte(3'b101, 0), ack); chk(!ack, "R7 no start nack", ack, 0);
        wr_byte(8'hA5, ack); chk(!ack, "R7 no start data nack", ack, 0);
        chk(rx_cnt == rxb, "R7 no rx after stop", rx_cnt - rxb, 0);
        scl_m = 1'b1; w(2*Q);
        bus_stop();

        // R9 short SDA pulse while SCL high is not a START
        w(2*Q);
        sda_m = 1'b0; w(3); sda_m = 1'b1; w(Q);
        scl_m = 1'b0; w(Q);
        wr_byte(addr_byte(3'b101, 0), ack); chk(!ack, "R9 glitch ignored", ack, 0);
        scl_m = 1'b1; w(2*Q);
        bus_stop();
        bus_start();
        wr_byte(addr_byte(3'b101, 0), ack); chk(ack, "R9 real start after glitch", ack, 1);
        bus_stop();

        // random transactions (R2 R3 R4)
        for (int t = 0; t < 8; t++) begin
            bit match, rd;
            logic [6:0] a7;
            int n;
            strap = 3'($urandom);
            w(Q);
            match = ($urandom % 3) != 0;
            rd = 1'($urandom);
            n = 1 + int'($urandom % 3);
            if (match) a7 = {HI, strap};
            else begin
                a7 = 7'($urandom);
                while (a7 == {HI, strap} || a7[6:2] == 5'b00001) a7 = 7'($urandom);
            end
            base = tx_i;
            rxb = rx_cnt;
            bus_start();
            wr_byte({a7, rd}, ack); chk(ack == match, "R2 random addr", ack, match);
            if (match && !rd) begin
                for (int k = 0; k < n; k++) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    wr_byte(d, ack); chk(ack, "R3 random ack", ack, 1);
                    chk(rx_log[(rxb + k) % 64] == d, "R3 random rx", rx_log[(rxb + k) % 64], d);
                end
            end else if (match && rd) begin
                for (int k = 0; k < n; k++) begin
                    rd_byte(k != n - 1, b);
                    chk(b == txv[(base + k) % 64], "R4 random read", b, txv[(base + k) % 64]);
                end
            end
            bus_stop();
            if (!match) chk(rx_cnt == rxb && tx_i == base, "R2 random no strobes", rx_cnt - rxb, 0);
        end

        chk(strobe_bad == 0, "R10 strobe width", strobe_bad, 0);
        finish_run();
    end
endmodule